// File: doc/BRIEF.md
# Indexed-Port Byte Memory with Lock Windows

This block puts a byte-wide internal memory behind a four-location I/O window. Software first loads a 16-bit address pointer one byte at a time: the low byte through offset 0 and the high byte through offset 1. It then moves data through offset 3. A data write stores the byte at the pointed address and returns the pointer to zero. A data read returns the byte at the pointed address and leaves the pointer unchanged. Offset 2 has no function.

Two lock bits each guard a fixed 16-byte region: bit 0 guards 0x20 to 0x2F and bit 1 guards 0x30 to 0x3F. A lock-toggle input with a one-bit selector flips the chosen lock bit. A blocked access reads 0xFF and its write is dropped. Any address at or above the configured memory size behaves the same way. The synchronous reset clears the pointer and both lock bits and keeps the memory contents.

Top module: `idx_nvram`

## Requirements
- R1: A write at offset 0 loads the write byte into pointer bits 7:0 and keeps pointer bits 15:8.
- R2: A write at offset 1 loads the write byte into pointer bits 15:8 and keeps pointer bits 7:0.
- R3: A write at offset 3 stores the write byte at the pointer address when that address is accessible. In every case the pointer becomes 0x0000 afterwards.
- R4: A read at offset 3 puts the byte at the pointer address on `rd_data` one clock after the read strobe. `rd_data` holds its value in cycles without a read strobe. A read does not change the pointer.
- R5: A read at offset 0, 1 or 2 returns 0xFF. A write at offset 2 changes neither the pointer nor the memory.
- R6: While lock bit 0 is set, addresses 0x20 to 0x2F read 0xFF and ignore writes. While lock bit 1 is set, addresses 0x30 to 0x3F do the same. Addresses outside a set lock's region are not affected by that lock.
- R7: A `lock_flip` pulse inverts the lock bit chosen by `lock_sel` (0 or 1) and leaves the other lock bit unchanged.
- R8: An address at or above MEM_BYTES (default 256) reads 0xFF, and a write there changes no memory byte.
- R9: Reset clears the pointer and both lock bits and sets `rd_data` to 0xFF. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_off | input | 2 | Offset within the four-byte window |
| wr_data | input | 8 | Byte written to the window |
| port_rd | input | 1 | Read strobe, one cycle per access |
| port_wr | input | 1 | Write strobe, one cycle per access |
| lock_flip | input | 1 | Pulse that inverts the selected lock bit |
| lock_sel | input | 1 | Lock bit chosen by `lock_flip` |
| rd_data | output | 8 | Registered read byte |

## Verification
On every cycle the assertions check the following:
- each pointer update and the return of the pointer to zero after a data write;
- the one-bit effect of a lock toggle;
- that a data write lands at the address that was pointed to;
- that reads at the spare offsets, reads in locked regions and reads above the memory all give 0xFF;
- that `rd_data` holds between reads.

Only the bench scenarios can show that memory survives reset, that a dropped write really left the old byte in place, and that each byte of the memory keeps its own value. The bench shows this by a full write-and-readback sweep, lock and unlock sequences with readback, and writes past the end of the memory followed by reads of the bytes they could alias onto.

// File: rtl/idx_nvram_pkg.sv
package idx_nvram_pkg;

  typedef enum logic [1:0] {
    OFF_PTR_LO = 2'd0,
    OFF_PTR_HI = 2'd1,
    OFF_SPARE  = 2'd2,
    OFF_DATA   = 2'd3
  } port_off_e;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  // True when address a lies in [base, base+span)
  function automatic logic in_window(input logic [31:0] a,
                                     input int unsigned base,
                                     input int unsigned span);
    return (a >= base) && (a < base + span);
  endfunction

  // True when address a falls inside a memory of the given size
  function automatic logic in_memory(input logic [31:0] a,
                                     input int unsigned size);
    return a < size;
  endfunction

  // One-hot mask for selected lock bit
  function automatic logic [31:0] sel_mask(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

endpackage

// File: rtl/idx_nvram_ptr.sv
module idx_nvram_ptr
  import idx_nvram_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PTR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        off,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr
);
  localparam int HI_W = PTR_W - BYTE_W;

  logic lo_load, hi_load, ptr_clear;
  assign lo_load   = wr && (off == OFF_PTR_LO);
  assign hi_load   = wr && (off == OFF_PTR_HI);
  assign ptr_clear = wr && (off == OFF_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (lo_load) begin
      ptr[BYTE_W-1:0] <= wdata;
    end else if (hi_load) begin
      ptr[PTR_W-1:BYTE_W] <= HI_W'(wdata);
    end else if (ptr_clear) begin
      ptr <= '0;
    end
  end

  AST_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
    lo_load |=> (ptr[BYTE_W-1:0] == $past(wdata)) &&
                (ptr[PTR_W-1:BYTE_W] == $past(ptr[PTR_W-1:BYTE_W]))); // R1
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
    hi_load |=> (ptr[PTR_W-1:BYTE_W] == HI_W'($past(wdata))) &&
                (ptr[BYTE_W-1:0] == $past(ptr[BYTE_W-1:0]))); // R2
  AST_PTR_AUTOCLEAR: assert property (@(posedge clk) disable iff (rst)
    ptr_clear |=> ptr == '0); // R3
  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(ptr)); // R4
  AST_PTR_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ptr == '0); // R9
endmodule

// File: rtl/idx_nvram_lock.sv
module idx_nvram_lock
  import idx_nvram_pkg::*;
#(
  parameter int LOCKS     = 2,
  parameter int SEL_W     = 1,
  parameter int PTR_W     = 16,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flip,
  input  logic [SEL_W-1:0] sel,
  input  logic [PTR_W-1:0] ptr,
  output logic [LOCKS-1:0] lock_q,
  output logic             blocked
);
  logic [LOCKS-1:0] hit;
  logic [LOCKS-1:0] flip_mask;

  assign flip_mask = flip ? LOCKS'(sel_mask(int'(sel))) : '0;

  always_ff @(posedge clk) begin
    if (rst) lock_q <= '0;
    else     lock_q <= lock_q ^ flip_mask;
  end

  for (genvar k = 0; k < LOCKS; k++) begin : g_win
    assign hit[k] = lock_q[k] &&
      in_window(32'(ptr), LOCK_BASE + k * LOCK_SPAN, LOCK_SPAN);
  end

  assign blocked = |hit;

  AST_TOGGLE_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    flip |=> $countones(lock_q ^ $past(lock_q)) == 1); // R7
  AST_NO_FLIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flip |=> $stable(lock_q)); // R7
  AST_LOCK_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lock_q == '0); // R9
endmodule

// File: rtl/idx_nvram_store.sv
module idx_nvram_store
  import idx_nvram_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int BYTE_W    = 8,
  parameter int PTR_W     = 16
) (
  input  logic              clk,
  input  logic              wen,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              in_range,
  output logic [BYTE_W-1:0] rbyte
);
  localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

  logic [BYTE_W-1:0] mem [MEM_BYTES];
  logic [IDX_W-1:0]  idx;
  logic              mem_wen;

  assign in_range = in_memory(32'(ptr), MEM_BYTES);
  assign idx      = IDX_W'(ptr);
  assign mem_wen  = wen && in_range;
  assign rbyte    = in_range ? mem[idx] : BYTE_W'(IDLE_BYTE);

  always_ff @(posedge clk) begin
    if (mem_wen) mem[idx] <= wdata;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk)
    mem_wen |=> mem[$past(idx)] == $past(wdata)); // R3
endmodule

// File: rtl/idx_nvram.sv
module idx_nvram
  import idx_nvram_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int LOCKS     = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] port_off,
  input  logic [7:0] wr_data,
  input  logic       port_rd,
  input  logic       port_wr,
  input  logic       lock_flip,
  input  logic [0:0] lock_sel,
  output logic [7:0] rd_data
);
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2 * BYTE_W;
  localparam int SEL_W  = 1;

  logic [PTR_W-1:0]  ptr;
  logic [LOCKS-1:0]  lock_q;
  logic              blocked;
  logic              in_range;
  logic [BYTE_W-1:0] rbyte;
  logic              data_wr, data_rd, store_wen;

  assign data_wr   = port_wr && (port_off == OFF_DATA);
  assign data_rd   = port_rd && (port_off == OFF_DATA);
  assign store_wen = data_wr && !blocked;

  idx_nvram_ptr #(.BYTE_W(BYTE_W), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .wr(port_wr), .off(port_off),
    .wdata(wr_data), .ptr(ptr)
  );

  idx_nvram_lock #(
    .LOCKS(LOCKS), .SEL_W(SEL_W), .PTR_W(PTR_W),
    .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
  ) u_lock (
    .clk(clk), .rst(rst), .flip(lock_flip), .sel(lock_sel),
    .ptr(ptr), .lock_q(lock_q), .blocked(blocked)
  );

  idx_nvram_store #(
    .MEM_BYTES(MEM_BYTES), .BYTE_W(BYTE_W), .PTR_W(PTR_W)
  ) u_store (
    .clk(clk), .wen(store_wen), .ptr(ptr), .wdata(wr_data),
    .in_range(in_range), .rbyte(rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= IDLE_BYTE;
    end else if (port_rd) begin
      rd_data <= (data_rd && !blocked) ? rbyte : IDLE_BYTE;
    end
  end

  AST_SPARE_OFF_RD: assert property (@(posedge clk) disable iff (rst)
    (port_rd && port_off != OFF_DATA) |=> rd_data == 8'hFF); // R5
  AST_LOCKED_RD: assert property (@(posedge clk) disable iff (rst)
    (data_rd && blocked) |=> rd_data == 8'hFF); // R6
  AST_OOR_RD: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !in_range) |=> rd_data == 8'hFF); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !port_rd |=> $stable(rd_data)); // R4
  AST_RD_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_data == 8'hFF); // R9
endmodule

// File: tb/idx_nvram_bench.sv
module idx_nvram_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] port_off = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       port_rd = 1'b0;
  logic       port_wr = 1'b0;
  logic       lock_flip = 1'b0;
  logic [0:0] lock_sel = 1'b0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  idx_nvram u_idx_nvram (
    .clk(clk), .rst(rst), .port_off(port_off), .wr_data(wr_data),
    .port_rd(port_rd), .port_wr(port_wr), .lock_flip(lock_flip),
    .lock_sel(lock_sel), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) % 256);
  endfunction

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    port_off = o; wr_data = d; port_wr = 1'b1;
    @(negedge clk);
    port_wr = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    wr_byte(2'd0, a[7:0]);
    wr_byte(2'd1, a[15:8]);
  endtask

  task automatic rd_byte(input logic [1:0] o, output logic [7:0] d);
    @(negedge clk);
    port_off = o; port_rd = 1'b1;
    @(negedge clk);
    port_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic mem_wr(input logic [15:0] a, input logic [7:0] d);
    set_ptr(a);
    wr_byte(2'd3, d);
  endtask

  task automatic mem_rd(input logic [15:0] a, output logic [7:0] d);
    set_ptr(a);
    rd_byte(2'd3, d);
  endtask

  task automatic flip(input logic s);
    @(negedge clk);
    lock_flip = 1'b1; lock_sel = s;
    @(negedge clk);
    lock_flip = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset rd_data", rd_data, 8'hFF);

    // Full sweep: write every byte, then read back (R3, R4)
    for (int a = 0; a < 256; a++) mem_wr(16'(a), pat(a));
    for (int a = 0; a < 256; a++) begin
      mem_rd(16'(a), v);
      check("R4 sweep readback", v, pat(a));
    end

    // R4 hold and pointer unchanged by read
    repeat (3) @(negedge clk);
    check("R4 rd_data hold", rd_data, pat(255));
    set_ptr(16'h0040);
    rd_byte(2'd3, v);
    rd_byte(2'd3, v);
    check("R4 read keeps pointer", v, pat(16'h40));

    // R1/R2 byte lanes
    set_ptr(16'h0112);
    rd_byte(2'd3, v);
    check("R2 high byte loaded (out of range)", v, 8'hFF);
    wr_byte(2'd1, 8'h00);
    rd_byte(2'd3, v);
    check("R2 high replaced, low kept", v, pat(16'h12));
    wr_byte(2'd0, 8'h45);
    rd_byte(2'd3, v);
    check("R1 low replaced, high kept", v, pat(16'h45));
    wr_byte(2'd1, 8'h01);
    wr_byte(2'd0, 8'h46);
    rd_byte(2'd3, v);
    check("R1 low load keeps high", v, 8'hFF);

    // R3 pointer clears after data write
    mem_wr(16'h0077, 8'hA5);
    rd_byte(2'd3, v);
    check("R3 pointer cleared to zero", v, pat(0));
    mem_rd(16'h0077, v);
    check("R3 stored value", v, 8'hA5);
    set_ptr(16'h0100);
    wr_byte(2'd3, 8'h3C);
    wr_byte(2'd0, 8'h10);
    rd_byte(2'd3, v);
    check("R3 clear after out of range write", v, pat(16'h10));

    // R5 spare offsets
    set_ptr(16'h0010);
    for (int o = 0; o < 3; o++) begin
      rd_byte(2'(o), v);
      check("R5 spare offset read", v, 8'hFF);
    end
    wr_byte(2'd2, 8'h55);
    rd_byte(2'd3, v);
    check("R5 offset2 write ignored", v, pat(16'h10));

    // R6/R7 lock windows
    flip(1'b0);
    for (int a = 16'h1F; a <= 16'h30; a++) begin
      mem_rd(16'(a), v);
      check("R6 lock0 window", v, (a >= 16'h20 && a <= 16'h2F) ? 8'hFF : pat(a));
    end
    mem_wr(16'h0025, 8'h00);
    flip(1'b0);
    mem_rd(16'h0025, v);
    check("R7 lock0 toggled off, R6 write dropped", v, pat(16'h25));
    flip(1'b1);
    for (int a = 16'h2F; a <= 16'h40; a++) begin
      mem_rd(16'(a), v);
      check("R6 lock1 window", v, (a >= 16'h30 && a <= 16'h3F) ? 8'hFF : pat(a));
    end
    mem_wr(16'h003A, 8'h00);
    mem_wr(16'h0029, 8'h99);
    flip(1'b1);
    mem_rd(16'h003A, v);
    check("R6 lock1 write dropped", v, pat(16'h3A));
    mem_rd(16'h0029, v);
    check("R6 lock1 leaves 0x29 writable", v, 8'h99);
    flip(1'b0);
    flip(1'b1);
    mem_rd(16'h0021, v);
    check("R7 both set, lock0", v, 8'hFF);
    mem_rd(16'h0031, v);
    check("R7 both set, lock1", v, 8'hFF);

    // R9 reset keeps memory, clears locks and pointer
    set_ptr(16'h0055);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R9 rd_data after reset", rd_data, 8'hFF);
    rd_byte(2'd3, v);
    check("R9 pointer cleared", v, pat(0));
    mem_rd(16'h0021, v);
    check("R9 lock0 cleared", v, pat(16'h21));
    mem_rd(16'h0031, v);
    check("R9 lock1 cleared", v, pat(16'h31));

    // R8 out of range
    mem_wr(16'h0100, 8'h11);
    mem_wr(16'hFFFF, 8'h22);
    mem_rd(16'h0000, v);
    check("R8 no alias at 0x00", v, pat(0));
    mem_rd(16'h00FF, v);
    check("R8 no alias at 0xFF", v, pat(255));
    mem_rd(16'h0100, v);
    check("R8 read 0x100", v, 8'hFF);
    mem_rd(16'hFFFF, v);
    check("R8 read 0xFFFF", v, 8'hFF);

    finish_run();
  end
endmodule